// File: doc/BRIEF.md
# Full-Frame CCD Readout Timing Generator

This block produces the digital clock pattern that reads one frame out of a single-output full-frame CCD. A start pulse opens an integration hold of programmable length, with both vertical phases held low. Each line of the frame is then moved down one row into the horizontal register by a non-overlapping two-phase vertical sequence. A programmable settling gap follows. The line is then shifted out pixel by pixel with complementary horizontal clocks. A separate last-stage horizontal phase, a reset-gate pulse and a converter sample strobe are generated inside every pixel period.

Within a pixel period the reset gate clears the output node first. The last-stage phase then falls and dumps the new charge packet. The sample strobe comes last, so every sample lands in the settled signal window, and every reset-gate pulse after the first one follows the sample of the previous pixel. Frame height, line length and clocks per pixel are parameters. Exposure length, vertical phase length and settling length are run-time inputs, and they must be held stable while a frame is being read out. All drive outputs are registered, so they follow the internal sequence by one clock.

Top module: `ccd_frame_sequencer`

## Requirements
- R1: During and after reset the outputs are at rest: v_a=0, v_b=0, h_a=1, h_b=0, h_last=1, rst_gate=0, smp=0, line_valid=0, frame_done=0.
- R2: A start sampled while idle begins integration with v_a and v_b low. The first v_a high appears max(exp_len,1)+1 clocks after the clock edge that sampled start.
- R3: Each line transfer runs v_a high for L clocks, then both low for L, then v_b high for L, then both low for L, where L = max(vph_len,1). v_a and v_b are never high together.
- R4: v_b falls exactly once per line, LINES times per frame, and h_a is high on every cycle in which v_b falls.
- R5: line_valid rises exactly L + settle_len clocks after the v_b falling edge of the same line.
- R6: line_valid stays high for LINE_PIX*PIX_CLKS clocks per line. While it is high, h_b is the complement of h_a, and h_a is high for the first PIX_CLKS/2 clocks of each pixel period.
- R7: h_last equals h_a at all times and falls exactly LINE_PIX times per line, once per pixel period.
- R8: rst_gate is high for one clock at offset 0 of every pixel period. smp is high for one clock at offset SAMP_OFS, where PIX_CLKS/2 < SAMP_OFS < PIX_CLKS. Each smp therefore follows a falling edge of h_last with no rst_gate in between.
- R9: frame_done is high for exactly one clock after the last pixel of the last line, and the outputs then return to the R1 levels.
- R10: A start that arrives while a frame is in progress is ignored: the frame completes unchanged and no second frame follows.
- R11: A synchronous reset asserted mid-frame returns every output to the R1 levels one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin integration and readout of one frame (accepted only when idle) |
| exp_len | input | EXP_W | Integration hold length in clocks (0 acts as 1) |
| vph_len | input | VPH_W | Clocks per vertical phase step (0 acts as 1) |
| settle_len | input | SET_W | Clocks between the end of a line transfer and the first pixel |
| v_a | output | 1 | First vertical transfer phase |
| v_b | output | 1 | Second vertical transfer phase; its falling edge loads a line |
| h_a | output | 1 | First horizontal phase |
| h_b | output | 1 | Second horizontal phase, complement of h_a during shifting |
| h_last | output | 1 | Last-stage horizontal phase; its falling edge dumps a packet |
| rst_gate | output | 1 | Output-node reset pulse |
| smp | output | 1 | Converter sample strobe |
| line_valid | output | 1 | High while a line is being shifted out |
| frame_done | output | 1 | One-clock pulse at the end of a frame |

## Verification
The hardest situation to reach from the ports is the relation between one line's v_b falling edge and its first horizontal cycle when the vertical phase length and the settling length both vary. That relation includes a zero phase length, which must behave as one clock, and a zero settling length, which skips the gap entirely. The stimulus table steps through these combinations. For every line, the bench timestamps the v_b falling edge and the line_valid rising edge and compares the distance against the value expected from the inputs. A start pulse is injected while line_valid is high so that an ignored restart can be observed. A reset is asserted in the middle of a shift to check the return to rest levels.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INTEG,
    ST_VXFER,
    ST_SETTLE,
    ST_HSHIFT
  } seq_state_t;

  typedef struct packed {
    logic v_a;
    logic v_b;
    logic h_a;
    logic h_b;
    logic h_last;
    logic rst_gate;
    logic smp;
    logic line_valid;
    logic frame_done;
  } ccd_drive_t;

  localparam ccd_drive_t DRIVE_REST = '{
    v_a: 1'b0, v_b: 1'b0, h_a: 1'b1, h_b: 1'b0, h_last: 1'b1,
    rst_gate: 1'b0, smp: 1'b0, line_valid: 1'b0, frame_done: 1'b0
  };

endpackage

// File: rtl/ccd_vert_clk.sv
// Two-phase non-overlapping vertical transfer engine: four equal steps
// (A high, gap, B high, gap) of phase_len clocks each.
module ccd_vert_clk #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [LEN_W-1:0] phase_len,
  output logic             v_a,
  output logic             v_b,
  output logic             done,
  output logic             active
);

  logic [1:0]       step_q;
  logic [LEN_W-1:0] cnt_q;
  logic             act_q;
  logic [LEN_W-1:0] len_eff;
  logic             step_last;

  assign len_eff   = (phase_len == '0) ? LEN_W'(1) : phase_len;
  assign step_last = (cnt_q == len_eff - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      step_q <= 2'd0;
      cnt_q  <= '0;
    end else if (go) begin
      act_q  <= 1'b1;
      step_q <= 2'd0;
      cnt_q  <= '0;
    end else if (act_q) begin
      if (step_last) begin
        cnt_q  <= '0;
        step_q <= step_q + 2'd1;
        if (step_q == 2'd3) act_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign v_a    = act_q && (step_q == 2'd0);
  assign v_b    = act_q && (step_q == 2'd2);
  assign done   = act_q && (step_q == 2'd3) && step_last;
  assign active = act_q;

  // R3: the sequence stops after the final gap step
  a_r3_seq_ends: assert property (@(posedge clk) disable iff (rst)
    (done && !go) |=> !act_q);

  // R3: B phase is always preceded by the gap step, never directly by A
  a_r3_b_after_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(v_b) |-> $past(act_q && step_q == 2'd1));

endmodule

// File: rtl/ccd_pix_clk.sv
// Horizontal pixel engine: one pixel period of PIX_CLKS clocks per
// pixel, LINE_PIX periods per line.
module ccd_pix_clk #(
  parameter int PIX_CLKS = 4,
  parameter int SAMP_OFS = 3,
  parameter int LINE_PIX = 4641
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic h_a,
  output logic h_b,
  output logic h_last,
  output logic rst_gate,
  output logic smp,
  output logic active,
  output logic line_end
);

  localparam int P_W = (PIX_CLKS > 1) ? $clog2(PIX_CLKS) : 1;
  localparam int X_W = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1;
  localparam logic [P_W-1:0] P_LAST = P_W'(PIX_CLKS - 1);
  localparam logic [P_W-1:0] P_HALF = P_W'(PIX_CLKS / 2);
  localparam logic [P_W-1:0] P_SAMP = P_W'(SAMP_OFS);
  localparam logic [X_W-1:0] X_LAST = X_W'(LINE_PIX - 1);

  logic [P_W-1:0] ph_q;
  logic [X_W-1:0] px_q;
  logic           act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      px_q  <= '0;
    end else if (go) begin
      act_q <= 1'b1;
      ph_q  <= '0;
      px_q  <= '0;
    end else if (act_q) begin
      if (ph_q == P_LAST) begin
        ph_q <= '0;
        if (px_q == X_LAST) act_q <= 1'b0;
        else                px_q  <= px_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  // h_a rests high outside a line so a line can be loaded under it
  assign h_a      = !act_q || (ph_q < P_HALF);
  assign h_b      = act_q && (ph_q >= P_HALF);
  assign h_last   = h_a;
  assign rst_gate = act_q && (ph_q == '0);
  assign smp      = act_q && (ph_q == P_SAMP);
  assign active   = act_q;
  assign line_end = act_q && (ph_q == P_LAST) && (px_q == X_LAST);

  // R7: the dump edge only happens inside a shifting line
  a_r7_dump_in_line: assert property (@(posedge clk) disable iff (rst)
    $fell(h_last) |-> act_q);

  // R6: a line ends after its last period unless restarted at once
  a_r6_line_closes: assert property (@(posedge clk) disable iff (rst)
    (line_end && !go) |=> !act_q);

endmodule

// File: rtl/ccd_seq_ctrl.sv
// Frame sequencer: integration hold, then per line a vertical transfer,
// an optional settling gap and a horizontal shift.
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int LINES = 3695,
  parameter int EXP_W = 32,
  parameter int SET_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [EXP_W-1:0] exp_len,
  input  logic [SET_W-1:0] settle_len,
  input  logic             vdone,
  input  logic             line_end,
  output logic             vgo,
  output logic             pgo,
  output logic             frame_end,
  output seq_state_t       state
);

  localparam int CW = (EXP_W > SET_W) ? EXP_W : SET_W;
  localparam int CX = CW + 1;
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [LW-1:0] L_LAST = LW'(LINES - 1);

  seq_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] line_q, line_d;
  logic [CX-1:0] cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + CX'(1);

  always_comb begin
    st_d      = st_q;
    cnt_d     = '0;
    line_d    = line_q;
    vgo       = 1'b0;
    pgo       = 1'b0;
    frame_end = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_INTEG;
          line_d = '0;
        end
      end
      ST_INTEG: begin
        if (cnt_inc >= CX'(exp_len)) begin
          st_d = ST_VXFER;
          vgo  = 1'b1;
        end else begin
          cnt_d = cnt_inc[CW-1:0];
        end
      end
      ST_VXFER: begin
        if (vdone) begin
          if (settle_len == '0) begin
            st_d = ST_HSHIFT;
            pgo  = 1'b1;
          end else begin
            st_d = ST_SETTLE;
          end
        end
      end
      ST_SETTLE: begin
        if (cnt_inc >= CX'(settle_len)) begin
          st_d = ST_HSHIFT;
          pgo  = 1'b1;
        end else begin
          cnt_d = cnt_inc[CW-1:0];
        end
      end
      ST_HSHIFT: begin
        if (line_end) begin
          if (line_q == L_LAST) begin
            st_d      = ST_IDLE;
            frame_end = 1'b1;
          end else begin
            st_d   = ST_VXFER;
            vgo    = 1'b1;
            line_d = line_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      line_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      line_q <= line_d;
    end
  end

  assign state = st_q;

  // R10: start has no effect while shifting a line
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HSHIFT && start && !line_end) |=> (st_q == ST_HSHIFT));

  // R2: integration leaves only towards a line transfer
  a_r2_integ_exit: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_INTEG) |=> (st_q == ST_INTEG || st_q == ST_VXFER));

  // R9: the frame ends only on the last line
  a_r9_last_line: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (line_q == L_LAST));

endmodule

// File: rtl/ccd_frame_sequencer.sv
module ccd_frame_sequencer
  import ccd_seq_pkg::*;
#(
  parameter int LINES    = 3695,
  parameter int LINE_PIX = 4641,
  parameter int PIX_CLKS = 4,
  parameter int SAMP_OFS = 3,
  parameter int EXP_W    = 32,
  parameter int VPH_W    = 8,
  parameter int SET_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [EXP_W-1:0] exp_len,
  input  logic [VPH_W-1:0] vph_len,
  input  logic [SET_W-1:0] settle_len,
  output logic             v_a,
  output logic             v_b,
  output logic             h_a,
  output logic             h_b,
  output logic             h_last,
  output logic             rst_gate,
  output logic             smp,
  output logic             line_valid,
  output logic             frame_done
);

  if (PIX_CLKS < 4 || SAMP_OFS <= PIX_CLKS / 2 || SAMP_OFS >= PIX_CLKS) begin : g_bad_cfg
    $error("SAMP_OFS must lie strictly between PIX_CLKS/2 and PIX_CLKS, PIX_CLKS >= 4");
  end

  logic       vgo, pgo, vdone, vact, line_end, frame_end;
  logic       va_c, vb_c, ha_c, hb_c, hl_c, rg_c, smp_c, pact;
  seq_state_t state;
  ccd_drive_t drive_d, drive_q;

  ccd_seq_ctrl #(
    .LINES (LINES),
    .EXP_W (EXP_W),
    .SET_W (SET_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .exp_len    (exp_len),
    .settle_len (settle_len),
    .vdone      (vdone),
    .line_end   (line_end),
    .vgo        (vgo),
    .pgo        (pgo),
    .frame_end  (frame_end),
    .state      (state)
  );

  ccd_vert_clk #(
    .LEN_W (VPH_W)
  ) u_vert (
    .clk       (clk),
    .rst       (rst),
    .go        (vgo),
    .phase_len (vph_len),
    .v_a       (va_c),
    .v_b       (vb_c),
    .done      (vdone),
    .active    (vact)
  );

  ccd_pix_clk #(
    .PIX_CLKS (PIX_CLKS),
    .SAMP_OFS (SAMP_OFS),
    .LINE_PIX (LINE_PIX)
  ) u_pix (
    .clk      (clk),
    .rst      (rst),
    .go       (pgo),
    .h_a      (ha_c),
    .h_b      (hb_c),
    .h_last   (hl_c),
    .rst_gate (rg_c),
    .smp      (smp_c),
    .active   (pact),
    .line_end (line_end)
  );

  always_comb begin
    drive_d            = DRIVE_REST;
    drive_d.v_a        = va_c;
    drive_d.v_b        = vb_c;
    drive_d.h_a        = ha_c;
    drive_d.h_b        = hb_c;
    drive_d.h_last     = hl_c;
    drive_d.rst_gate   = rg_c;
    drive_d.smp        = smp_c;
    drive_d.line_valid = pact;
    drive_d.frame_done = frame_end;
  end

  always_ff @(posedge clk) begin
    if (rst) drive_q <= DRIVE_REST;
    else     drive_q <= drive_d;
  end

  assign v_a        = drive_q.v_a;
  assign v_b        = drive_q.v_b;
  assign h_a        = drive_q.h_a;
  assign h_b        = drive_q.h_b;
  assign h_last     = drive_q.h_last;
  assign rst_gate   = drive_q.rst_gate;
  assign smp        = drive_q.smp;
  assign line_valid = drive_q.line_valid;
  assign frame_done = drive_q.frame_done;

  // Tracks whether a packet has been dumped since the last node reset.
  logic hl_prev_q, dumped_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      hl_prev_q <= 1'b1;
      dumped_q  <= 1'b0;
    end else begin
      hl_prev_q <= drive_q.h_last;
      if (drive_q.rst_gate)                     dumped_q <= 1'b0;
      else if (hl_prev_q && !drive_q.h_last)    dumped_q <= 1'b1;
    end
  end

  // R8: a sample always follows a dump with no node reset in between
  a_r8_sample_after_dump: assert property (@(posedge clk) disable iff (rst)
    drive_q.smp |-> dumped_q);

  // R2: vertical phases stay low throughout integration
  a_r2_integ_v_low: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INTEG) |=> (!drive_q.v_a && !drive_q.v_b));

  // R3: vertical phases never overlap
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(drive_q.v_a && drive_q.v_b));

  // R4: a line is loaded only with h_a held high
  a_r4_load_under_ha: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_q.v_b) |-> drive_q.h_a);

  // R6: horizontal phases are complementary while shifting
  a_r6_h_complement: assert property (@(posedge clk) disable iff (rst)
    drive_q.line_valid |-> (drive_q.h_b == !drive_q.h_a));

  // R11: one clock after reset every output is at rest
  a_r11_reset_rest: assert property (@(posedge clk)
    $past(rst) |-> (drive_q == DRIVE_REST));

endmodule

// File: tb/sim_ccd_frame_sequencer.sv
`timescale 1ns/1ps
module sim_ccd_frame_sequencer;

  localparam int LINES    = 3;
  localparam int LINE_PIX = 5;
  localparam int PIX_CLKS = 4;
  localparam int SAMP_OFS = 3;

  // fields: exp_len, vph_len, settle_len, expected start->v_a delay, inject start
  localparam logic [39:0] VEC [0:3] = '{
    40'h00_01_00_03_00,
    40'h05_02_03_07_01,
    40'h01_03_00_03_00,
    40'h0C_00_07_0E_00
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] exp_len = '0;
  logic [7:0]  vph_len = 8'd1;
  logic [15:0] settle_len = '0;
  logic v_a, v_b, h_a, h_b, h_last, rst_gate, smp, line_valid, frame_done;

  always #5 clk = ~clk;

  ccd_frame_sequencer #(
    .LINES(LINES), .LINE_PIX(LINE_PIX), .PIX_CLKS(PIX_CLKS), .SAMP_OFS(SAMP_OFS)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .exp_len(exp_len), .vph_len(vph_len),
    .settle_len(settle_len), .v_a(v_a), .v_b(v_b), .h_a(h_a), .h_b(h_b),
    .h_last(h_last), .rst_gate(rst_gate), .smp(smp), .line_valid(line_valid),
    .frame_done(frame_done)
  );

  int nchk = 0;
  int nfail = 0;
  int pcnt = 0;
  always @(posedge clk) pcnt <= pcnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (pcnt > 100000) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=<100000", pcnt);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  // monitor state
  bit mon_en = 0;
  int cur_l, cur_s;
  int first_va, va_run, v2_at;
  bit seen_va, dumped;
  int ovl_err, run_err, hb_err, gap_err, cmp_err, fol_err, ord_err;
  int vb_falls, lv_rises, lv_cyc, hl_falls, rg_cnt, smp_cnt, fd_cnt;
  logic va_p, vb_p, lv_p, hl_p;

  task automatic clear_mon();
    first_va = -1; seen_va = 0; va_run = 0; v2_at = 0; dumped = 0;
    ovl_err = 0; run_err = 0; hb_err = 0; gap_err = 0; cmp_err = 0;
    fol_err = 0; ord_err = 0; vb_falls = 0; lv_rises = 0; lv_cyc = 0;
    hl_falls = 0; rg_cnt = 0; smp_cnt = 0; fd_cnt = 0;
    va_p = v_a; vb_p = v_b; lv_p = line_valid; hl_p = h_last;
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (v_a && !seen_va) begin first_va = pcnt; seen_va = 1; end
      if (v_a && v_b) ovl_err++;
      if (v_a) va_run++;
      else if (va_p) begin if (va_run != cur_l) run_err++; va_run = 0; end
      if (!v_b && vb_p) begin vb_falls++; if (!h_a) hb_err++; v2_at = pcnt; end
      if (line_valid && !lv_p) begin
        lv_rises++;
        if (pcnt - v2_at != cur_l + cur_s) gap_err++;
      end
      if (line_valid) begin lv_cyc++; if (h_b == h_a) cmp_err++; end
      if (!h_last && hl_p) begin hl_falls++; dumped = 1; end
      if (h_last != h_a) fol_err++;
      if (rst_gate) begin rg_cnt++; dumped = 0; end
      if (smp) begin smp_cnt++; if (!dumped) ord_err++; end
      if (frame_done) fd_cnt++;
      va_p = v_a; vb_p = v_b; lv_p = line_valid; hl_p = h_last;
    end
  end

  task automatic check_rest(input string req);
    chk({req, " v_a"}, int'(v_a), 0);
    chk({req, " v_b"}, int'(v_b), 0);
    chk({req, " h_a"}, int'(h_a), 1);
    chk({req, " h_b"}, int'(h_b), 0);
    chk({req, " h_last"}, int'(h_last), 1);
    chk({req, " rst_gate"}, int'(rst_gate), 0);
    chk({req, " smp"}, int'(smp), 0);
    chk({req, " line_valid"}, int'(line_valid), 0);
    chk({req, " frame_done"}, int'(frame_done), 0);
  endtask

  task automatic run_row(input logic [39:0] row);
    int t0, guard;
    bit inj, injected;
    exp_len    = 32'(row[39:32]);
    vph_len    = row[31:24];
    settle_len = 16'(row[23:16]);
    inj        = row[0];
    injected   = 0;
    cur_l = (vph_len == 0) ? 1 : int'(vph_len);
    cur_s = int'(settle_len);
    mon_en = 0;
    @(negedge clk);
    clear_mon();
    mon_en = 1;
    start = 1'b1;
    t0 = pcnt;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (fd_cnt == 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (inj && !injected && line_valid) begin start = 1'b1; injected = 1; end
      else start = 1'b0;
    end
    start = 1'b0;
    chk("R9 frame finished", int'(guard < 20000), 1);
    repeat (300) @(negedge clk);
    chk("R2 start to v_a delay", first_va - t0, int'(row[15:8]));
    chk("R3 overlap count", ovl_err, 0);
    chk("R3 v_a run length errors", run_err, 0);
    chk("R4 v_b falls per frame", vb_falls, LINES);
    chk("R4 h_a low at v_b fall", hb_err, 0);
    chk("R5 settle gap errors", gap_err, 0);
    chk("R5 line_valid rises", lv_rises, LINES);
    chk("R6 line_valid cycles", lv_cyc, LINES * LINE_PIX * PIX_CLKS);
    chk("R6 complement errors", cmp_err, 0);
    chk("R7 h_last falls", hl_falls, LINES * LINE_PIX);
    chk("R7 h_last follow errors", fol_err, 0);
    chk("R8 rst_gate pulses", rg_cnt, LINES * LINE_PIX);
    chk("R8 smp pulses", smp_cnt, LINES * LINE_PIX);
    chk("R8 order errors", ord_err, 0);
    chk(inj ? "R10 frames after mid-frame start" : "R9 frame_done cycles", fd_cnt, 1);
    check_rest("R9 rest after frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_rest("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_rest("R1 after reset");

    for (int i = 0; i < 4; i++) run_row(VEC[i]);

    // R11: reset in the middle of a line shift
    exp_len = 32'd2; vph_len = 8'd1; settle_len = 16'd0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int g = 0; g < 200 && !line_valid; g++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R11 shifting before reset", int'(line_valid), 1);
    rst = 1'b1;
    @(negedge clk);
    check_rest("R11 mid-frame reset");
    rst = 1'b0;
    repeat (50) @(negedge clk);
    chk("R11 stays idle after reset", int'(line_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule